// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns the synchronized levels of a 32-pin port into interrupt requests. Each pin has its own control word, and a 4-bit detection code in that word picks the condition that raises the pin's request. The code can select no detection, a low or high level, a rising edge, a falling edge, or either edge. A detected condition sets that pin's bit in a shared status register. Software clears status bits by writing ones to them. One combined interrupt line is asserted while any status bit is set.

Software reaches the block through a simple 32-bit register bus. A write happens on any clock edge with the write strobe high. Reads are combinational from the address. The block expects its pin inputs to be synchronized to its clock already. Edge detection compares each pin with its own level one cycle earlier, and that earlier level is tracked whether or not detection is enabled.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset every control word reads 0, the status register reads 0 and `irq_out` is low.
- R2: The control word of pin n is at byte offset 4*n (n = 0..31). A write stores only bits 19:16 as the detection code, and a read returns that code in bits 19:16 with every other bit 0.
- R3: Code 0x0 disables detection, and so do the unlisted codes (any code other than 0x8, 0x9, 0xA, 0xB, 0xC). A disabled pin never sets its status bit, whatever its level does.
- R4: Code 0x8 (level low) sets the pin's status bit on every clock edge at which the pin is 0.
- R5: Code 0xC (level high) sets the pin's status bit on every clock edge at which the pin is 1.
- R6: Code 0x9 (rising edge) sets the status bit once, at the first clock edge where the pin is 1 after being sampled 0 at the previous edge. A pin that stays high sets nothing further.
- R7: Code 0xA (falling edge) sets the status bit once on each 1-to-0 transition of the pin.
- R8: Code 0xB (either edge) sets the status bit on each transition in either direction.
- R9: The status register is at offset 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, a 0 bit leaves it as it is, and writing all ones clears every bit. Without such a write, status bits never drop.
- R10: When a detection and a clear hit the same bit at the same clock edge, the bit stays set. A level condition that persists therefore sets its bit again right after a clear.
- R11: `irq_out` is high exactly while at least one status bit is set.
- R12: The previous-level reference is tracked while a pin is disabled. If a rising-edge code is enabled while the pin is already high, no event is flagged until the pin falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels, bit n for pin n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear and a new detection landing on the same status bit at the same clock edge. The bench brings it about in two ways. First, it raises a pin configured for rising edges and issues the clear for that pin's bit at the same falling clock edge, so both take effect together. Second, it clears a bit while a level condition is still present. The other hard case is enabling edge detection on a pin that is already high, which shows whether the edge reference was kept up to date while the pin was disabled.

// File: rtl/pid_pkg.sv
`timescale 1ns/1ps
package pid_pkg;
    localparam int MODE_W   = 4;
    localparam int MODE_LSB = 16;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF  = 4'h0,
        MD_LOW  = 4'h8,
        MD_RISE = 4'h9,
        MD_FALL = 4'hA,
        MD_BOTH = 4'hB,
        MD_HIGH = 4'hC
    } mode_e;

    // Evaluate one pin's detection condition for its code.
    function automatic logic eval_hit(logic [MODE_W-1:0] code, logic lvl, logic prev);
        logic r;
        case (code)
            MD_LOW:  r = ~lvl;
            MD_HIGH: r = lvl;
            MD_RISE: r = lvl & ~prev;
            MD_FALL: r = ~lvl & prev;
            MD_BOTH: r = lvl ^ prev;
            default: r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pid_cfg_regs.sv
`timescale 1ns/1ps
module pid_cfg_regs
    import pid_pkg::*;
#(
    parameter int NPIN = 32,
    localparam int IDX_W = $clog2(NPIN)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [MODE_W-1:0]                wval,
    output logic [NPIN-1:0][MODE_W-1:0]      mode
);
    typedef struct packed {
        logic [NPIN-1:0][MODE_W-1:0] mode;
    } cfg_s;

    cfg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mode[idx] = wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
endmodule

// File: rtl/pid_detect.sv
`timescale 1ns/1ps
module pid_detect
    import pid_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPIN-1:0]              pin_lvl,
    input  logic [NPIN-1:0][MODE_W-1:0]  mode,
    output logic [NPIN-1:0]              hit_vec
);
    typedef struct packed {
        logic [NPIN-1:0] prev;
    } det_s;

    det_s st_d, st_q;

    // The reference level follows the pin regardless of the code.
    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            hit_vec[i] = eval_hit(mode[i], pin_lvl[i], st_q.prev[i]);
        end
    end
endmodule

// File: rtl/pid_flags.sv
`timescale 1ns/1ps
module pid_flags #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] hit_vec,
    input  logic [NPIN-1:0] clr_vec,
    output logic [NPIN-1:0] flags
);
    typedef struct packed {
        logic [NPIN-1:0] flags;
    } flg_s;

    flg_s st_d, st_q;

    // A set and a clear on the same bit: the set is kept.
    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_vec) | hit_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/pin_irq_detector.sv
`timescale 1ns/1ps
module pin_irq_detector
    import pid_pkg::*;
#(
    parameter int NPIN     = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int STAT_OFS = 'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_lvl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);
    localparam int IDX_W     = $clog2(NPIN);
    localparam int CTRL_SPAN = NPIN * 4;

    logic                        ctrl_hit;
    logic                        stat_hit;
    logic [IDX_W-1:0]            idx;
    logic [NPIN-1:0][MODE_W-1:0] cfg_mode;
    logic [NPIN-1:0]             hit_vec;
    logic [NPIN-1:0]             clr_vec;
    logic [NPIN-1:0]             flags;

    always_comb begin
        ctrl_hit = (addr[1:0] == 2'b00) && (int'(addr) < CTRL_SPAN);
        stat_hit = (int'(addr) == STAT_OFS);
        idx      = addr[2 +: IDX_W];
        clr_vec  = (wr_en && stat_hit) ? wdata[NPIN-1:0] : '0;
    end

    pid_cfg_regs #(.NPIN(NPIN)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && ctrl_hit),
        .idx   (idx),
        .wval  (wdata[MODE_LSB +: MODE_W]),
        .mode  (cfg_mode)
    );

    pid_detect #(.NPIN(NPIN)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .mode    (cfg_mode),
        .hit_vec (hit_vec)
    );

    pid_flags #(.NPIN(NPIN)) u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    always_comb begin
        rdata = '0;
        if (ctrl_hit) begin
            rdata[MODE_LSB +: MODE_W] = cfg_mode[idx];
        end else if (stat_hit) begin
            rdata[NPIN-1:0] = flags;
        end
    end

    assign irq_out = |flags;
endmodule

// File: rtl/pid_chk.sv
`timescale 1ns/1ps
module pid_chk #(
    parameter int NPIN     = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int STAT_OFS = 'hA0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [NPIN-1:0]   hit_vec,
    input logic [NPIN-1:0]   flags,
    input logic              irq_out
);
    logic stat_wr;
    assign stat_wr = wr_en && (int'(addr) == STAT_OFS);

    // R9: a written one leaves the bit clear unless a detection hit it.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((flags & $past(wdata[NPIN-1:0]) & ~$past(hit_vec)) == '0));

    // R9: without a clear write, no status bit drops.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((~flags & $past(flags)) == '0));

    // R10: every detected bit is set on the next cycle, clear or not.
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |=> ((flags & $past(hit_vec)) == $past(hit_vec)));

    // R11: the combined line only rises after a detection.
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ($past(hit_vec) != '0));
endmodule

bind pin_irq_detector pid_chk #(
    .NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .hit_vec (hit_vec),
    .flags   (flags),
    .irq_out (irq_out)
);

// File: tb/sim_pin_irq_detector.sv
`timescale 1ns/1ps
module sim_pin_irq_detector;
    localparam logic [7:0] STAT = 8'hA0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pin_irq_detector u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic set_pin(int n, logic v);
        @(negedge clk);
        pins[n] = v;
    endtask

    task automatic cleanup();
        for (int i = 0; i < 32; i++) wr(8'(i * 4), 32'h0);
        pins = '0;
        @(negedge clk);
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(STAT, d);     chk("R1 status", d, 32'h0);
        rd(8'h14, d);    chk("R1 ctrl5", d, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d);    chk("R2 ctrl3 masked", d, 32'h000F_0000);
        wr(8'h7C, 32'h123C_4567);
        rd(8'h7C, d);    chk("R2 ctrl31", d, 32'h000C_0000);
        rd(8'h08, d);    chk("R2 ctrl2 untouched", d, 32'h0);
        cleanup();
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(8'h10, 32'h0000_0000);
        wr(8'h14, 32'h0005_0000);
        set_pin(4, 1'b1); set_pin(5, 1'b1);
        set_pin(4, 1'b0); set_pin(5, 1'b0);
        @(negedge clk);
        rd(STAT, d);     chk("R3 off/unlisted", d, 32'h0);
        cleanup();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(8'h1C, 32'h0008_0000);               // pin 7 low-level, pin low now
        rd(STAT, d);     chk("R4 low level", d, 32'h80);
        chk("R11 irq high", {31'b0, irq_out}, 32'h1);
        wr(STAT, 32'h80);
        rd(STAT, d);     chk("R10 level re-sets", d, 32'h80);
        set_pin(7, 1'b1);
        wr(STAT, 32'h80);
        rd(STAT, d);     chk("R4 cleared when high", d, 32'h0);
        chk("R11 irq low", {31'b0, irq_out}, 32'h0);
        wr(8'h24, 32'h000C_0000);               // pin 9 high-level
        rd(STAT, d);     chk("R5 idle low", d, 32'h0);
        set_pin(9, 1'b1);
        @(negedge clk);
        rd(STAT, d);     chk("R5 high level", d, 32'h200);
        cleanup();
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(8'h28, 32'h0009_0000);               // pin 10 rising
        wr(8'h2C, 32'h000A_0000);               // pin 11 falling
        wr(8'h30, 32'h000B_0000);               // pin 12 both
        set_pin(10, 1'b1); set_pin(11, 1'b1);
        @(negedge clk);
        rd(STAT, d);     chk("R6 rise / R7 no fall on rise", d, 32'h400);
        wr(STAT, 32'h400);
        repeat (3) @(negedge clk);
        rd(STAT, d);     chk("R6 held high no repeat", d, 32'h0);
        set_pin(11, 1'b0);
        @(negedge clk);
        rd(STAT, d);     chk("R7 fall", d, 32'h800);
        wr(STAT, 32'hFFFF_FFFF);
        set_pin(12, 1'b1);
        @(negedge clk);
        rd(STAT, d);     chk("R8 both rising", d, 32'h1000);
        wr(STAT, 32'h1000);
        set_pin(12, 1'b0);
        @(negedge clk);
        rd(STAT, d);     chk("R8 both falling", d, 32'h1000);
        cleanup();
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h00, 32'h000C_0000);
        wr(8'h04, 32'h000C_0000);
        wr(8'h08, 32'h000C_0000);
        @(negedge clk); pins[2:0] = 3'b111;
        @(negedge clk); pins[2:0] = 3'b000;
        @(negedge clk);
        rd(STAT, d);     chk("R9 three set", d, 32'h7);
        wr(STAT, 32'h0);
        rd(STAT, d);     chk("R9 zero write", d, 32'h7);
        wr(STAT, 32'h2);
        rd(STAT, d);     chk("R9 partial clear", d, 32'h5);
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, d);     chk("R9 clear all", d, 32'h0);
        chk("R11 irq off", {31'b0, irq_out}, 32'h0);
        cleanup();
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        wr(8'h34, 32'h0009_0000);               // pin 13 rising
        @(negedge clk);
        pins[13] = 1'b1;
        wr_en = 1'b1; addr = STAT; wdata = 32'h2000;
        @(negedge clk);
        wr_en = 1'b0;
        rd(STAT, d);     chk("R10 set beats clear", d, 32'h2000);
        cleanup();
    endtask

    task automatic t_tracking();
        logic [31:0] d;
        set_pin(14, 1'b1);                      // rises while disabled
        repeat (2) @(negedge clk);
        wr(8'h38, 32'h0009_0000);
        repeat (2) @(negedge clk);
        rd(STAT, d);     chk("R12 no stale edge", d, 32'h0);
        set_pin(14, 1'b0); set_pin(14, 1'b1);
        @(negedge clk);
        rd(STAT, d);     chk("R12 next real edge", d, 32'h4000);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_disabled();
        t_level();
        t_edges();
        t_w1c();
        t_setwins();
        t_tracking();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule